// File: doc/BRIEF.md
# Request/Grant Pulse Bus Arbiter

This block decides when a processor's bus unit gives its local bus to one of several external masters, and when it takes the bus back. Each external master has one active-low request/grant wire. Here that wire is split into an input (`rq_n_i`) and an output (`gt_n_o`). A complete exchange on a wire is three one-clock low pulses. The master sends a request pulse. The arbiter answers with a grant pulse. Later the master sends a release pulse.

The arbiter watches the state of the processor's bus sequencer: whether a cycle is running, the current T-state, and three flags on the cycle in progress. These flags mark an odd-address low byte, the first interrupt acknowledge, and a locked instruction. The release only happens at a point where handing over the bus cannot split an access that must stay whole.

Towards the bus sequencer the arbiter drives three outputs. `float_o` tells the pads to stop driving the bus. `busy_o` tells the sequencer not to start a cycle. `ctl_oe_o` is the output enable of the status, lock and control pins. The arbiter also produces the bus lock output, which merges the locked-instruction flag with the lock window of the interrupt acknowledge pair.

Top module: `rqgt_arb`

## Requirements
- R1: After reset, every `gt_n_o` line is high, `float_o` and `busy_o` are low, `ctl_oe_o` is high and `lock_n_o` is high.
- R2: A request is one clock of `rq_n_i[k]` low. If it is sampled while no bus cycle runs (`cyc_act_i`=0) and `lock_i` is low, `gt_n_o[k]` is low for the very next clock, and `float_o` and `busy_o` are high in that clock.
- R3: T-state is encoded on `tstate_i` as 0=T1, 1=T2, 2=T3 or wait, 3=T4. During a running cycle, a request sampled in T1 or T2 gives a grant pulse in the clock after T4. A grant pulse never follows a clock that was neither T4 nor bus idle.
- R4: A request first sampled in T3, a wait state or T4 gets no grant after that T4. It is served after the T4 of the next cycle, or as soon as the bus is idle.
- R5: The T4 of a cycle with `odd_lo_i`=1, or with `inta_i`=1 and `inta_first_i`=1, releases nothing. A request waiting on such a cycle is served later.
- R6: No grant pulse appears in the clock after `lock_i` was high.
- R7: When several lines want the bus in the same decision, the lowest index wins. Line 0 beats line 1.
- R8: A grant pulse lasts exactly one clock. After the owner's release pulse, `float_o` is low in the next clock. That clock is a gap clock: `busy_o` is high and there is no grant. After the gap, `busy_o` goes low.
- R9: A request from another line that arrives while the bus is granted or held is remembered. It is served after the gap clock.
- R10: While `float_o` is high, `ctl_oe_o` is low and `lock_n_o` is high, whatever the value of `lock_i`.
- R11: With the bus not floated, `lock_n_o` is low whenever `lock_i` is high. It is also low from T2 of a first interrupt acknowledge cycle until T2 of the second one; in that second T2 it is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rq_n_i | input | N_LINES | Request and release pulses from the masters, active low |
| gt_n_o | output | N_LINES | Grant pulse to each master, active low |
| cyc_act_i | input | 1 | A bus cycle is running |
| tstate_i | input | 2 | T-state of the running cycle (0=T1, 1=T2, 2=T3/wait, 3=T4) |
| odd_lo_i | input | 1 | Running cycle is the low byte of a word at an odd address |
| inta_i | input | 1 | Running cycle is an interrupt acknowledge |
| inta_first_i | input | 1 | Running interrupt acknowledge is the first of its pair |
| lock_i | input | 1 | A locked instruction is executing |
| float_o | output | 1 | Bus pads released to the other master |
| busy_o | output | 1 | Sequencer must not start a cycle |
| ctl_oe_o | output | 1 | Output enable for status, lock and control pins |
| lock_n_o | output | 1 | Bus lock output, active low |

## Verification
Some properties are checked by assertions on every clock:
- grant pulses stay single and one-hot (R8, R10);
- a grant is only ever preceded by a T4 or an idle clock, and never by an active lock (R3, R6);
- the clock after the bus is reclaimed carries no grant (R8);
- the pins read high while floated (R10);
- the lock window opens only after T2 of a first interrupt acknowledge (R11);
- a grant goes only to a line that asked (R7).

Other behaviours need history that spans several bus cycles, so only the bench's scenarios can show them:
- a late request deferred to the next cycle (R4);
- a request blocked by an odd-address low byte or a first acknowledge and then served (R5);
- line 0 preferred over line 1 (R7);
- a request remembered across a whole exchange on the other line (R9).

// File: rtl/rqgt_pkg.sv
package rqgt_pkg;
  typedef enum logic [1:0] {
    TS_T1 = 2'd0,
    TS_T2 = 2'd1,
    TS_T3 = 2'd2,
    TS_T4 = 2'd3
  } tstate_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_GNT  = 2'd1,
    ST_HELD = 2'd2,
    ST_GAP  = 2'd3
  } arb_st_e;
endpackage

// File: rtl/rqgt_line.sv
module rqgt_line (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rq_n_i,
  input  logic owned_i,
  input  logic held_i,
  input  logic take_i,
  output logic want_o,
  output logic rel_o
);
  logic pend_q;
  logic req;

  // a low pulse from the current owner is a release, from anyone else a request
  assign req    = !rq_n_i && !owned_i;
  assign rel_o  = !rq_n_i && held_i;
  assign want_o = pend_q || req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= want_o && !take_i;
  end

  p_take_want_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> want_o);
endmodule

// File: rtl/rqgt_qual.sv
module rqgt_qual import rqgt_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cyc_act_i,
  input  logic [1:0] tstate_i,
  input  logic       odd_lo_i,
  input  logic       inta_i,
  input  logic       inta_first_i,
  input  logic       lock_i,
  input  logic       want_any_i,
  output logic       can_rel_o
);
  tstate_e ts;
  logic    early_q;
  logic    t4_ok;

  assign ts = tstate_e'(tstate_i);

  // demand seen no later than T2 of the running cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                              early_q <= 1'b0;
    else if (cyc_act_i && (ts == TS_T1 || ts == TS_T2) && want_any_i) early_q <= 1'b1;
    else if (cyc_act_i && ts == TS_T4)                        early_q <= 1'b0;
  end

  assign t4_ok     = (ts == TS_T4) && early_q && !odd_lo_i && !(inta_i && inta_first_i);
  assign can_rel_o = want_any_i && !lock_i && (!cyc_act_i || t4_ok);
endmodule

// File: rtl/rqgt_lock.sv
module rqgt_lock import rqgt_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cyc_act_i,
  input  logic [1:0] tstate_i,
  input  logic       inta_i,
  input  logic       inta_first_i,
  input  logic       lock_i,
  input  logic       float_i,
  output logic       lock_n_o
);
  logic ia_q;
  logic t2_ia;
  logic set_now;
  logic clr_now;

  assign t2_ia   = cyc_act_i && (tstate_e'(tstate_i) == TS_T2) && inta_i;
  assign set_now = t2_ia && inta_first_i;
  assign clr_now = t2_ia && !inta_first_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ia_q <= 1'b0;
    else if (set_now) ia_q <= 1'b1;
    else if (clr_now) ia_q <= 1'b0;
  end

  // floated pin reads as a held-high level
  assign lock_n_o = float_i || !(lock_i || set_now || (ia_q && !clr_now));

  p_ia_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ia_q) |-> $past(cyc_act_i && tstate_i == 2'd1 && inta_i && inta_first_i));
endmodule

// File: rtl/rqgt_arb.sv
module rqgt_arb import rqgt_pkg::*; #(
  parameter int unsigned N_LINES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] rq_n_i,
  output logic [N_LINES-1:0] gt_n_o,
  input  logic               cyc_act_i,
  input  logic [1:0]         tstate_i,
  input  logic               odd_lo_i,
  input  logic               inta_i,
  input  logic               inta_first_i,
  input  logic               lock_i,
  output logic               float_o,
  output logic               busy_o,
  output logic               ctl_oe_o,
  output logic               lock_n_o
);
  localparam int unsigned OW = (N_LINES > 1) ? $clog2(N_LINES) : 1;

  arb_st_e            st_q, st_d;
  logic [OW-1:0]      own_q, own_d, sel;
  logic [N_LINES-1:0] want, rel, owned, held, take;
  logic               want_any, can_rel, grant_now, rel_any, on_bus;

  assign on_bus    = (st_q == ST_GNT) || (st_q == ST_HELD);
  assign want_any  = |want;
  assign rel_any   = |rel;
  assign grant_now = (st_q == ST_IDLE) && can_rel;

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = int'(N_LINES) - 1; i >= 0; i--)
      if (want[i]) sel = OW'(i);
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign owned[g]  = on_bus && (own_q == OW'(g));
    assign held[g]   = (st_q == ST_HELD) && (own_q == OW'(g));
    assign take[g]   = grant_now && (sel == OW'(g));
    assign gt_n_o[g] = !((st_q == ST_GNT) && (own_q == OW'(g)));

    rqgt_line u_line (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .rq_n_i  (rq_n_i[g]),
      .owned_i (owned[g]),
      .held_i  (held[g]),
      .take_i  (take[g]),
      .want_o  (want[g]),
      .rel_o   (rel[g])
    );
  end

  rqgt_qual u_qual (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cyc_act_i    (cyc_act_i),
    .tstate_i     (tstate_i),
    .odd_lo_i     (odd_lo_i),
    .inta_i       (inta_i),
    .inta_first_i (inta_first_i),
    .lock_i       (lock_i),
    .want_any_i   (want_any),
    .can_rel_o    (can_rel)
  );

  always_comb begin
    st_d  = st_q;
    own_d = own_q;
    unique case (st_q)
      ST_IDLE: if (grant_now) begin st_d = ST_GNT; own_d = sel; end
      ST_GNT:  st_d = ST_HELD;
      ST_HELD: if (rel_any) st_d = ST_GAP;
      ST_GAP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      own_q <= '0;
    end else begin
      st_q  <= st_d;
      own_q <= own_d;
    end
  end

  assign float_o  = on_bus;
  assign busy_o   = (st_q != ST_IDLE);
  assign ctl_oe_o = !on_bus;

  rqgt_lock u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cyc_act_i    (cyc_act_i),
    .tstate_i     (tstate_i),
    .inta_i       (inta_i),
    .inta_first_i (inta_first_i),
    .lock_i       (lock_i),
    .float_i      (on_bus),
    .lock_n_o     (lock_n_o)
  );

  p_gt_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~gt_n_o));
  p_gt_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gt_n_o != '1) |=> (gt_n_o == '1));
  p_gt_window_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gt_n_o != '1) |-> $past(!cyc_act_i || tstate_i == 2'd3));
  p_lock_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gt_n_o != '1) |-> $past(!lock_i));
  p_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(float_o) |-> busy_o ##1 (gt_n_o == '1));
  p_hiz_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_oe_o |-> lock_n_o);
endmodule

// File: tb/test_rqgt_arb.sv
module test_rqgt_arb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] d_rq = 2'b11;
  logic       d_cyc = 1'b0, d_odd = 1'b0, d_ia = 1'b0, d_iaf = 1'b0, d_lk = 1'b0;
  logic [1:0] d_t = 2'd0;
  logic [1:0] gt_n;
  logic       float_w, busy_w, oe_w, lockn_w;

  int checks = 0;
  int fails  = 0;

  // reference state
  int       m_st = 0;
  bit       m_own = 1'b0;
  bit [1:0] m_pend = 2'b00;
  bit       m_early = 1'b0, m_ia = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rqgt_arb #(.N_LINES(2)) i_rqgt_arb (
    .clk_i(clk), .rst_ni(rst_n), .rq_n_i(d_rq), .gt_n_o(gt_n),
    .cyc_act_i(d_cyc), .tstate_i(d_t), .odd_lo_i(d_odd), .inta_i(d_ia),
    .inta_first_i(d_iaf), .lock_i(d_lk), .float_o(float_w), .busy_o(busy_w),
    .ctl_oe_o(oe_w), .lock_n_o(lockn_w)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic model_cmp();
    bit [1:0] e_gt;
    bit e_fl, e_lockn, set_now, clr_now;
    e_fl    = (m_st == 1) || (m_st == 2);
    e_gt    = (m_st == 1) ? (m_own ? 2'b01 : 2'b10) : 2'b11;
    set_now = d_cyc && d_t == 2'd1 && d_ia && d_iaf;
    clr_now = d_cyc && d_t == 2'd1 && d_ia && !d_iaf;
    e_lockn = e_fl || !(d_lk || set_now || (m_ia && !clr_now));
    chk(gt_n == e_gt, "R3 grant lines", gt_n, e_gt);
    chk(float_w == e_fl, "R8 float", float_w, e_fl);
    chk(busy_w == (m_st != 0), "R2 busy", busy_w, m_st != 0);
    chk(oe_w == !e_fl, "R10 ctl_oe", oe_w, !e_fl);
    chk(lockn_w == e_lockn, "R11 lock_n", lockn_w, e_lockn);
  endtask

  task automatic model_step();
    bit [1:0] rqv, wnt;
    bit rel, wany, ok, gr, sel;
    for (int k = 0; k < 2; k++)
      rqv[k] = !d_rq[k] && !(((m_st == 1) || (m_st == 2)) && m_own == k[0]);
    rel  = (m_st == 2) && !d_rq[m_own];
    wnt  = m_pend | rqv;
    wany = |wnt;
    ok   = !d_lk && wany && (!d_cyc || (d_t == 2'd3 && m_early && !d_odd && !(d_ia && d_iaf)));
    gr   = (m_st == 0) && ok;
    sel  = wnt[0] ? 1'b0 : 1'b1;
    if (d_cyc && d_t <= 2'd1 && wany) m_early = 1'b1;
    else if (d_cyc && d_t == 2'd3)    m_early = 1'b0;
    if (d_cyc && d_t == 2'd1 && d_ia) m_ia = d_iaf;
    for (int k = 0; k < 2; k++) m_pend[k] = wnt[k] && !(gr && sel == k[0]);
    case (m_st)
      0: if (gr) begin m_st = 1; m_own = sel; end
      1: m_st = 2;
      2: if (rel) m_st = 3;
      default: m_st = 0;
    endcase
  endtask

  task automatic step(input bit c, input logic [1:0] t, input bit od, input bit ia,
                      input bit iaf, input bit lk, input logic [1:0] rq);
    @(negedge clk);
    d_cyc = c; d_t = t; d_odd = od; d_ia = ia; d_iaf = iaf; d_lk = lk; d_rq = rq;
    #1;
    model_cmp();
    @(posedge clk);
    model_step();
  endtask

  task automatic look_gt(input logic [1:0] exp, input string tag);
    #2;
    chk(gt_n == exp, tag, gt_n, exp);
  endtask

  task automatic idle(input logic [1:0] rq);
    step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, rq);
  endtask

  task automatic bus(input logic [1:0] t, input bit od, input bit ia, input bit iaf, input logic [1:0] rq);
    step(1'b1, t, od, ia, iaf, 1'b0, rq);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    bit s_cyc, s_odd, s_ia, s_iaf, s_lk, ia2_due;
    logic [1:0] s_t;
    bit [1:0] prev_low;
    void'($urandom(32'h5eed_0a1b));

    // R1 reset values
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(gt_n == 2'b11, "R1 gt reset", gt_n, 3);
    chk(float_w == 1'b0, "R1 float reset", float_w, 0);
    chk(busy_w == 1'b0, "R1 busy reset", busy_w, 0);
    chk(oe_w == 1'b1, "R1 oe reset", oe_w, 1);
    chk(lockn_w == 1'b1, "R1 lock reset", lockn_w, 1);
    rst_n = 1'b1;

    // R2 idle grant next clock, R10 pins high while floated, R8 gap
    idle(2'b10);  look_gt(2'b10, "R2 idle grant");
    chk(float_w && busy_w && !oe_w, "R2 float on grant", {float_w, busy_w, oe_w}, 3'b110);
    step(1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b11);
    #2 chk(lockn_w == 1'b1, "R10 lock high while floated", lockn_w, 1);
    idle(2'b10);  #2 chk(!float_w && busy_w, "R8 reclaim gap", {float_w, busy_w}, 2'b01);
    idle(2'b11);  #2 chk(!busy_w, "R8 gap ends", busy_w, 0);

    // R3 request in T1 granted after T4
    bus(2'd0, 0, 0, 0, 2'b10); look_gt(2'b11, "R3 no grant in T1");
    bus(2'd1, 0, 0, 0, 2'b11);
    bus(2'd2, 0, 0, 0, 2'b11);
    bus(2'd3, 0, 0, 0, 2'b11); look_gt(2'b10, "R3 grant after T4");
    idle(2'b11); idle(2'b10); idle(2'b11);

    // R4 late request waits one cycle
    bus(2'd0, 0, 0, 0, 2'b11);
    bus(2'd1, 0, 0, 0, 2'b11);
    bus(2'd2, 0, 0, 0, 2'b10);
    bus(2'd3, 0, 0, 0, 2'b11); look_gt(2'b11, "R4 late request deferred");
    bus(2'd0, 0, 0, 0, 2'b11);
    bus(2'd1, 0, 0, 0, 2'b11);
    bus(2'd2, 0, 0, 0, 2'b11);
    bus(2'd3, 0, 0, 0, 2'b11); look_gt(2'b10, "R4 served next cycle");
    idle(2'b11); idle(2'b10); idle(2'b11);

    // R5 odd low byte blocks, idle bus then serves
    bus(2'd0, 1, 0, 0, 2'b10);
    bus(2'd1, 1, 0, 0, 2'b11);
    bus(2'd2, 1, 0, 0, 2'b11);
    bus(2'd3, 1, 0, 0, 2'b11); look_gt(2'b11, "R5 odd low byte holds bus");
    idle(2'b11); look_gt(2'b10, "R5 served when idle");
    idle(2'b11); idle(2'b10); idle(2'b11);

    // R5 and R11 interrupt acknowledge pair
    bus(2'd0, 0, 1, 1, 2'b10);
    bus(2'd1, 0, 1, 1, 2'b11); #2 chk(lockn_w == 1'b0, "R11 lock in first T2", lockn_w, 0);
    bus(2'd2, 0, 1, 1, 2'b11); #2 chk(lockn_w == 1'b0, "R11 lock held", lockn_w, 0);
    bus(2'd3, 0, 1, 1, 2'b11); look_gt(2'b11, "R5 first acknowledge holds bus");
    bus(2'd0, 0, 1, 0, 2'b11); #2 chk(lockn_w == 1'b0, "R11 lock across pair", lockn_w, 0);
    bus(2'd1, 0, 1, 0, 2'b11); #2 chk(lockn_w == 1'b1, "R11 lock clears in second T2", lockn_w, 1);
    bus(2'd2, 0, 1, 0, 2'b11);
    bus(2'd3, 0, 1, 0, 2'b11); look_gt(2'b10, "R5 second acknowledge releases");
    idle(2'b11); idle(2'b10); idle(2'b11);

    // R6 locked instruction blocks
    step(1'b0, 2'd0, 0, 0, 0, 1'b1, 2'b10); look_gt(2'b11, "R6 lock blocks");
    step(1'b0, 2'd0, 0, 0, 0, 1'b1, 2'b11); look_gt(2'b11, "R6 lock still blocks");
    #2 chk(lockn_w == 1'b0, "R11 lock_i drives lock", lockn_w, 0);
    idle(2'b11); look_gt(2'b10, "R6 served after unlock");
    idle(2'b11); idle(2'b10); idle(2'b11);

    // R7 priority, R8 gap, R9 remembered request
    idle(2'b00);  look_gt(2'b10, "R7 line 0 wins");
    idle(2'b11);
    idle(2'b10);  look_gt(2'b11, "R8 no grant at reclaim");
    idle(2'b11);  look_gt(2'b11, "R8 no grant in gap");
    idle(2'b11);  look_gt(2'b01, "R9 waiting line served");
    idle(2'b11); idle(2'b01); idle(2'b11);

    // R9 request while another line holds the bus
    idle(2'b10);
    idle(2'b01);
    idle(2'b11);
    idle(2'b10);
    idle(2'b11);  look_gt(2'b11, "R9 not during gap");
    idle(2'b11);  look_gt(2'b01, "R9 served after gap");
    idle(2'b11); idle(2'b01); idle(2'b11); idle(2'b11);

    // random traffic against the reference
    s_cyc = 0; s_t = 2'd0; s_odd = 0; s_ia = 0; s_iaf = 0; s_lk = 0; ia2_due = 0;
    prev_low = 2'b00;
    for (int n = 0; n < 6000; n++) begin
      bit [1:0] nrq;
      nrq = 2'b11;
      for (int k = 0; k < 2; k++) begin
        if (prev_low[k]) continue;
        if (m_st == 2 && m_own == k[0]) begin
          if ($urandom % 6 == 0) nrq[k] = 1'b0;
        end else if (!(m_st == 1 && m_own == k[0]) && $urandom % 12 == 0) begin
          nrq[k] = 1'b0;
        end
      end
      if ($urandom % 40 == 0) s_lk = !s_lk;
      step(s_cyc, s_t, s_odd, s_ia, s_iaf, s_lk, nrq);
      prev_low = ~nrq;
      if (s_cyc && s_t != 2'd3) begin
        if (!(s_t == 2'd2 && $urandom % 4 == 0)) s_t = s_t + 2'd1;
      end else begin
        s_cyc = 0; s_odd = 0; s_ia = 0; s_iaf = 0;
        if (m_st == 0 && (ia2_due || $urandom % 3 != 0)) begin
          s_cyc = 1; s_t = 2'd0;
          if (ia2_due) begin s_ia = 1; s_iaf = 0; ia2_due = 0; end
          else if ($urandom % 8 == 0) begin s_ia = 1; s_iaf = 1; ia2_due = 1; end
          else s_odd = ($urandom % 4 == 0);
        end
      end
    end

    summary();
    $finish;
  end
endmodule